// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Port

This block is the digital front end of a two-channel, serially loaded digital-to-analog converter. Each channel has four wires from the host: an active-low frame sync, a serial clock, a serial data line and an active-low load strobe. A frame carries 16 data bits, one per falling serial-clock edge while frame sync is low. The last `RES_BITS` bits of the frame form the DAC code, MSB first. The bits in front of the code are padding and are thrown away. A completed frame is placed in a per-channel input register. The load strobe then moves it into a holding register, which is the code the converter uses.

All host wires are asynchronous to the system clock. Each wire passes through a two-flop synchronizer, and its edges are found by comparing the synchronized level with a copy delayed by one cycle. The system clock must run at least four times faster than any serial clock.

The frame sequencer in each channel has three states:
- `FR_IDLE` waits for frame sync to fall, then moves to `FR_SHIFT`.
- `FR_SHIFT` counts captured bits. On the sixteenth bit it moves to `FR_FULL`. It returns to `FR_IDLE` (abort) if frame sync goes high first.
- `FR_FULL` ignores further clock edges and returns to `FR_IDLE` once frame sync goes high.

A small arbiter beside the sequencer decides when the holding register is written. It follows the level and falling edge of the load strobe and whether a frame is in flight.

Top module: `sdac_dual_port`

## Requirements
- R1: While frame sync is low, a frame captures one data bit on each falling serial-clock edge. The first bit sent becomes bit 15 of the 16-bit frame word and the last bit sent becomes bit 0.
- R2: A frame starts only on a falling edge of frame sync. If frame sync returns high before the sixteenth edge, the frame is dropped and the input register keeps its previous code.
- R3: Serial-clock edges after the sixteenth edge of a frame are ignored: neither the input register nor the outputs change.
- R4: The code is frame word bits [RES_BITS-1:0], in two's complement, with the top bits discarded as padding. With RES_BITS=12 the range is -2048..+2047; with RES_BITS=14 it is -8192..+8191.
- R5: A falling load-strobe edge while no frame is in flight copies the input register to the holding register. `upd_o` pulses high for one cycle when this happens.
- R6: If the load strobe is low when the sixteenth edge of a frame is captured, the holding register takes the new code and `upd_o` pulses.
- R7: A falling load-strobe edge while a frame is being shifted in causes no update by itself.
- R8: If the load strobe falls during a frame and is high again before the frame completes, that frame produces no update. Its code stays in the input register for a later strobe.
- R9: The channels are fully independent. Activity on one channel never changes the other channel's code or update pulse.
- R10: A synchronous reset sets the input and holding registers of both channels to code zero, drops any partial frame, and holds `upd_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fs_n_i | input | NUM_CH | Per-channel frame sync, active low, asynchronous |
| sclk_i | input | NUM_CH | Per-channel serial clock, asynchronous |
| sdi_i | input | NUM_CH | Per-channel serial data |
| ld_n_i | input | NUM_CH | Per-channel load strobe, active low, asynchronous |
| code_o | output | NUM_CH*RES_BITS | Holding-register codes; channel c occupies bits [c*RES_BITS +: RES_BITS] |
| upd_o | output | NUM_CH | One-cycle pulse when the channel's holding register is written |

## Verification
The bench builds two copies of the block with NUM_CH=2: one with RES_BITS=14 and one with RES_BITS=12. Both copies are driven from the same serial wires. Every frame is therefore decoded twice, once with two padding bits and once with four, so both code slices and both signed ranges are checked against the same stimulus. This covers the most negative and most positive codes, and words whose padding bits are set. Two channels let the bench run simultaneous frames and check that a strobe on one channel leaves the other untouched.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    // Bits per serial frame; the code occupies the tail of the frame.
    localparam int FRAME_LEN = 16;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_FULL  = 2'd2
    } frame_st_e;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            lvl_q  <= RST_VAL;
        end else begin
            meta_q <= async_i;
            lvl_q  <= meta_q;
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/sdac_framer.sv
module sdac_framer
    import sdac_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_LEN,
    parameter int RES_BITS   = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fs_lvl,
    input  logic                fs_fall,
    input  logic                sclk_fall,
    input  logic                sdi_lvl,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] fresh_code_o,
    output logic [RES_BITS-1:0] latched_code_o
);

    localparam int              CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    frame_st_e           st_q, st_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [RES_BITS-2:0] sh_q;
    logic [RES_BITS-1:0] lat_q;
    logic                take;
    logic [RES_BITS-1:0] shifted;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= FR_IDLE;
        else     st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE:  if (fs_fall) st_d = FR_SHIFT;
            FR_SHIFT: begin
                if (fs_lvl)                          st_d = FR_IDLE;
                else if (sclk_fall && cnt_q == LAST) st_d = FR_FULL;
            end
            FR_FULL:  if (fs_lvl) st_d = FR_IDLE;
            default:  st_d = FR_IDLE;
        endcase
    end

    assign take    = (st_q == FR_SHIFT) && !fs_lvl && sclk_fall;
    assign shifted = {sh_q, sdi_lvl};

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
            lat_q <= '0;
        end else begin
            if (st_q == FR_IDLE) cnt_q <= '0;
            if (take) begin
                sh_q  <= shifted[RES_BITS-2:0];
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) lat_q <= shifted;
            end
        end
    end

    assign busy_o         = (st_q == FR_SHIFT);
    assign done_o         = take && (cnt_q == LAST);
    assign fresh_code_o   = shifted;
    assign latched_code_o = lat_q;

    // R3
    extra_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_FULL) |=> $stable(lat_q));

    // R2
    abort_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == FR_SHIFT && fs_lvl) |=> (st_q == FR_IDLE && $stable(lat_q)));

    // R1
    one_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/sdac_loader.sv
module sdac_loader #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_lvl,
    input  logic                ld_fall,
    input  logic                busy,
    input  logic                done,
    input  logic [RES_BITS-1:0] fresh_code,
    input  logic [RES_BITS-1:0] latched_code,
    output logic [RES_BITS-1:0] hold_o,
    output logic                upd_o
);

    logic [RES_BITS-1:0] hold_q, hold_d;
    logic                upd_q, upd_d;

    always_comb begin
        hold_d = hold_q;
        upd_d  = 1'b0;
        if (done && !ld_lvl) begin
            hold_d = fresh_code;
            upd_d  = 1'b1;
        end else if (ld_fall && !busy) begin
            hold_d = latched_code;
            upd_d  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            hold_q <= hold_d;
            upd_q  <= upd_d;
        end
    end

    assign hold_o = hold_q;
    assign upd_o  = upd_q;

    // R5
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_fall && !busy) |=> (upd_q && hold_q == $past(latched_code)));

    // R6
    held_low_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ld_lvl) |=> (upd_q && hold_q == $past(fresh_code)));

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && ld_fall) |=> !upd_q);

    // R8
    released_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ld_lvl) |=> !upd_q);

    // R10
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hold_q == '0 && !upd_q));

endmodule

// File: rtl/sdac_dual_port.sv
module sdac_dual_port
    import sdac_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int RES_BITS = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CH-1:0]          fs_n_i,
    input  logic [NUM_CH-1:0]          sclk_i,
    input  logic [NUM_CH-1:0]          sdi_i,
    input  logic [NUM_CH-1:0]          ld_n_i,
    output logic [NUM_CH*RES_BITS-1:0] code_o,
    output logic [NUM_CH-1:0]          upd_o
);

    // Sync vector layout: {frame sync, serial clock, data, load strobe}
    localparam logic [3:0] SYNC_RST = 4'b1101;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [3:0]          lvl;
        logic [2:0]          prev_q;
        logic                fs_fall, sclk_fall, ld_fall;
        logic                busy, done;
        logic [RES_BITS-1:0] fresh, latched;

        sdac_sync #(.WIDTH(4), .RST_VAL(SYNC_RST)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i ({fs_n_i[c], sclk_i[c], sdi_i[c], ld_n_i[c]}),
            .lvl_o   (lvl)
        );

        always_ff @(posedge clk) begin
            if (rst) prev_q <= 3'b111;
            else     prev_q <= {lvl[3], lvl[2], lvl[0]};
        end

        assign fs_fall   = prev_q[2] && !lvl[3];
        assign sclk_fall = prev_q[1] && !lvl[2];
        assign ld_fall   = prev_q[0] && !lvl[0];

        sdac_framer #(.FRAME_BITS(FRAME_LEN), .RES_BITS(RES_BITS)) u_framer (
            .clk            (clk),
            .rst            (rst),
            .fs_lvl         (lvl[3]),
            .fs_fall        (fs_fall),
            .sclk_fall      (sclk_fall),
            .sdi_lvl        (lvl[1]),
            .busy_o         (busy),
            .done_o         (done),
            .fresh_code_o   (fresh),
            .latched_code_o (latched)
        );

        sdac_loader #(.RES_BITS(RES_BITS)) u_loader (
            .clk          (clk),
            .rst          (rst),
            .ld_lvl       (lvl[0]),
            .ld_fall      (ld_fall),
            .busy         (busy),
            .done         (done),
            .fresh_code   (fresh),
            .latched_code (latched),
            .hold_o       (code_o[c*RES_BITS +: RES_BITS]),
            .upd_o        (upd_o[c])
        );
    end

endmodule

// File: tb/sdac_dual_port_test.sv
module sdac_dual_port_test;

    localparam int HALF = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic [1:0] fs_n, sclk, sdi, ld_n;
    wire  [27:0] c14;
    wire  [23:0] c12;
    wire  [1:0]  u14, u12;

    sdac_dual_port #(.NUM_CH(2), .RES_BITS(14)) uut (
        .clk(clk), .rst(rst), .fs_n_i(fs_n), .sclk_i(sclk), .sdi_i(sdi),
        .ld_n_i(ld_n), .code_o(c14), .upd_o(u14));

    sdac_dual_port #(.NUM_CH(2), .RES_BITS(12)) uut_n (
        .clk(clk), .rst(rst), .fs_n_i(fs_n), .sclk_i(sclk), .sdi_i(sdi),
        .ld_n_i(ld_n), .code_o(c12), .upd_o(u12));

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R10";
    logic [15:0] q14a[$], q14b[$], q12a[$], q12b[$];
    logic [15:0] lastw [2];
    logic [15:0] inreg [2];
    logic [15:0] e14, e12;

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic wcyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int ch, logic [15:0] w);
        if (ch == 0) begin q14a.push_back(w); q12a.push_back(w); end
        else         begin q14b.push_back(w); q12b.push_back(w); end
        lastw[ch] = w;
    endtask

    task automatic check_hold(int ch);
        chk("hold wide",   {2'b0, c14[ch*14 +: 14]}, {2'b0, lastw[ch][13:0]});
        chk("hold narrow", {4'b0, c12[ch*12 +: 12]}, {4'b0, lastw[ch][11:0]});
    endtask

    task automatic drained();
        chk("pending updates", 16'(q14a.size() + q14b.size() + q12a.size() + q12b.size()), 16'd0);
    endtask

    task automatic send(int ch, logic [15:0] w, int nedge, int fall_at, int rise_at);
        @(negedge clk);
        fs_n[ch] = 1'b0;
        wcyc(HALF);
        for (int i = 0; i < nedge; i++) begin
            if (i == fall_at) ld_n[ch] = 1'b0;
            if (i == rise_at) ld_n[ch] = 1'b1;
            sdi[ch] = (i < 16) ? w[15-i] : i[0];
            wcyc(HALF);
            sclk[ch] = 1'b0;
            wcyc(HALF);
            sclk[ch] = 1'b1;
        end
        if (nedge >= 16) inreg[ch] = w;
        wcyc(HALF);
        fs_n[ch] = 1'b1;
        wcyc(12);
    endtask

    task automatic ld_low(int ch);
        push(ch, inreg[ch]);
        ld_n[ch] = 1'b0;
        wcyc(8);
    endtask

    task automatic pulse_ld(int ch);
        push(ch, inreg[ch]);
        ld_n[ch] = 1'b0;
        wcyc(6);
        ld_n[ch] = 1'b1;
        wcyc(12);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int ch = 0; ch < 2; ch++) begin
                if (u14[ch]) begin
                    if ((ch == 0 ? q14a.size() : q14b.size()) == 0) begin
                        vectors++; miscompares++;
                        $display("FAIL %s unexpected wide update ch%0d: got %h expected none",
                                 cur_req, ch, c14[ch*14 +: 14]);
                    end else begin
                        if (ch == 0) e14 = q14a.pop_front(); else e14 = q14b.pop_front();
                        chk("wide code", {2'b0, c14[ch*14 +: 14]}, {2'b0, e14[13:0]});
                    end
                end
                if (u12[ch]) begin
                    if ((ch == 0 ? q12a.size() : q12b.size()) == 0) begin
                        vectors++; miscompares++;
                        $display("FAIL %s unexpected narrow update ch%0d: got %h expected none",
                                 cur_req, ch, c12[ch*12 +: 12]);
                    end else begin
                        if (ch == 0) e12 = q12a.pop_front(); else e12 = q12b.pop_front();
                        chk("narrow code", {4'b0, c12[ch*12 +: 12]}, {4'b0, e12[11:0]});
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1; fs_n = 2'b11; sclk = 2'b11; sdi = 2'b00; ld_n = 2'b11;
        lastw[0] = '0; lastw[1] = '0; inreg[0] = '0; inreg[1] = '0;
        wcyc(5);
        rst = 1'b0;
        wcyc(5);

        // R10: reset state
        cur_req = "R10";
        check_hold(0); check_hold(1);
        chk("update pulses", {12'b0, u14, u12}, 16'd0);

        // R1 / R4 / R6: strobe held low, update on sixteenth edge
        cur_req = "R6";
        ld_low(0);
        push(0, 16'hA5C3);
        send(0, 16'hA5C3, 16, -1, -1);
        drained();
        ld_n[0] = 1'b1; wcyc(10);
        cur_req = "R1";
        check_hold(0);

        // R5: frame with strobe high, then strobe pulse
        cur_req = "R5";
        send(0, 16'h0F0F, 16, -1, -1);
        check_hold(0);
        pulse_ld(0);
        drained();
        check_hold(0);

        // R3: extra clock edges ignored
        cur_req = "R3";
        ld_low(0);
        push(0, 16'h3C5A);
        send(0, 16'h3C5A, 21, -1, -1);
        ld_n[0] = 1'b1; wcyc(10);
        check_hold(0);
        pulse_ld(0);
        drained();
        check_hold(0);

        // R7: strobe falls mid-frame, stays low
        cur_req = "R7";
        push(0, 16'h1234);
        send(0, 16'h1234, 16, 5, -1);
        drained();
        check_hold(0);
        ld_n[0] = 1'b1; wcyc(10);

        // R8: strobe falls and rises mid-frame
        cur_req = "R8";
        send(0, 16'hFEDC, 16, 4, 10);
        check_hold(0);
        drained();
        pulse_ld(0);
        drained();
        check_hold(0);

        // R2: aborted frame leaves input register intact
        cur_req = "R2";
        send(0, 16'h5555, 8, -1, -1);
        check_hold(0);
        pulse_ld(0);
        drained();
        check_hold(0);

        // R4: extreme codes on channel 1
        cur_req = "R4";
        ld_low(1);
        push(1, 16'h07FF); send(1, 16'h07FF, 16, -1, -1);
        chk("narrow max", 16'($signed(c12[23:12])), 16'h07FF);
        push(1, 16'hF800); send(1, 16'hF800, 16, -1, -1);
        chk("narrow min", 16'($signed(c12[23:12])), 16'hF800);
        chk("wide neg",   16'($signed(c14[27:14])), 16'hF800);
        push(1, 16'h2000); send(1, 16'h2000, 16, -1, -1);
        chk("wide min",   16'($signed(c14[27:14])), 16'hE000);
        chk("narrow pad", 16'($signed(c12[23:12])), 16'h0000);
        push(1, 16'h1FFF); send(1, 16'h1FFF, 16, -1, -1);
        chk("wide max",   16'($signed(c14[27:14])), 16'h1FFF);
        chk("narrow m1",  16'($signed(c12[23:12])), 16'hFFFF);
        ld_n[1] = 1'b1; wcyc(10);
        drained();

        // R9: simultaneous frames, then one-sided strobe
        cur_req = "R9";
        ld_low(0); ld_low(1);
        push(0, 16'h9ABC); push(1, 16'h4321);
        fork
            send(0, 16'h9ABC, 16, -1, -1);
            send(1, 16'h4321, 16, -1, -1);
        join
        ld_n = 2'b11; wcyc(10);
        drained();
        check_hold(0); check_hold(1);
        pulse_ld(1);
        drained();
        check_hold(0); check_hold(1);

        // R10: reset in the middle of a frame
        cur_req = "R10";
        fork
            send(0, 16'hFFFF, 16, -1, -1);
            begin wcyc(60); rst = 1'b1; wcyc(3); rst = 1'b0; end
        join
        lastw[0] = '0; lastw[1] = '0; inreg[0] = '0;
        wcyc(5);
        check_hold(0); check_hold(1);
        pulse_ld(0);
        drained();
        check_hold(0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule